// File: doc/BRIEF.md
# Periodic Interval Timer

The block generates a repeating single-cycle strobe whose spacing is set by a programmable interval. A binary down-counter decrements on every enabled clock. When it reaches zero, a NOR of its bits raises the output strobe. That same zero detect reloads the counter from the interval register, so the strobe recurs every interval+1 clocks for as long as the block is enabled. A parent module changes the interval through a write strobe and a data bus. The new value is used at the next reload and never disturbs a period that is already running.

A small controller tracks two phases. In `PH_TERMINAL` the count is zero and the next enabled clock reloads it. In `PH_COUNTING` the count is nonzero and the next enabled clock decrements it. There are three transitions:

- `PH_TERMINAL` to `PH_COUNTING` on an enabled clock when the interval is nonzero.
- `PH_TERMINAL` to `PH_TERMINAL` on an enabled clock when the interval is zero.
- `PH_COUNTING` to `PH_TERMINAL` on an enabled clock when the count is one.

When the enable is low, the phase and the count both hold. The reset style, asynchronous or synchronous, is chosen by a parameter.

Top module: `interval_pulse_gen`

## Requirements
- R1: Reset clears the count to zero. With the enable low after reset there is no strobe. The first clock with the enable high produces a strobe.
- R2: With the enable held high and an interval N of 1 or more, the strobe is high for exactly one cycle in every N+1 cycles. After each strobe the count restarts from N.
- R3: With an interval of 0 and the enable high, the strobe is high on every cycle.
- R4: While the enable is low the strobe stays low and the count holds. Raising the enable again continues the period where it stopped.
- R5: A write to the interval register changes neither the count in progress nor the reload that happens in the same cycle as the write. The new value is first used at the following reload.
- R6: The interval register resets to DEFAULT_INTERVAL, which is 0 by default. Without any write, the strobe therefore fires on every enabled cycle after reset.
- R7: The full-scale interval of 2^W-1 gives a spacing of 2^W cycles between strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (asynchronous or synchronous by parameter) |
| en_i | input | 1 | Count enable; low freezes the count and suppresses the strobe |
| wr_i | input | 1 | Interval write strobe |
| wr_data_i | input | W | Interval value written when wr_i is high |
| pulse_o | output | 1 | One-cycle strobe, high while enabled at count zero |

## Verification
Several properties are checked on every cycle:

- Each reload loads the interval register's value from the cycle before.
- Each enabled clock with a nonzero count lowers the count by one.
- A disabled cycle leaves the count unchanged and produces no strobe.
- The strobe never stays high twice in a row when the interval is nonzero.
- The controller's phase always agrees with the counter's zero detect.

Only the bench's scenarios show the end-to-end behaviour: the spacing between strobes, the timing of a write relative to the reload, the resumption after a pause, and the full-scale period.

// File: rtl/ipg_pkg.sv
package ipg_pkg;

    // Phase of the period tracked by the controller
    typedef enum logic [0:0] {
        PH_TERMINAL = 1'b0,   // count is zero, next enabled clock reloads
        PH_COUNTING = 1'b1    // count is nonzero, next enabled clock decrements
    } ipg_phase_e;

    // Command issued to the down-counter each clock
    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_DEC  = 2'd1,
        CMD_LOAD = 2'd2
    } ipg_cmd_e;

endpackage

// File: rtl/ipg_interval_reg.sv
module ipg_interval_reg #(
    parameter int          W         = 16,
    parameter bit          ASYNC_RST = 1'b1,
    parameter logic [W-1:0] RST_VAL  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] interval_o,
    output logic         interval_zero_o
);

    logic [W-1:0] interval_q;

    generate
        if (ASYNC_RST) begin : g_async
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    interval_q <= RST_VAL;
                end else if (wr_i) begin
                    interval_q <= wr_data_i;
                end
            end
        end else begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    interval_q <= RST_VAL;
                end else if (wr_i) begin
                    interval_q <= wr_data_i;
                end
            end
        end
    endgenerate

    assign interval_o      = interval_q;
    assign interval_zero_o = ~|interval_q;

endmodule

// File: rtl/ipg_down_counter.sv
module ipg_down_counter
    import ipg_pkg::*;
#(
    parameter int W         = 16,
    parameter bit ASYNC_RST = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  ipg_cmd_e     cmd_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] cnt_o,
    output logic         zero_o,
    output logic         one_o
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;

    always_comb begin
        unique case (cmd_i)
            CMD_HOLD: cnt_d = cnt_q;
            CMD_DEC:  cnt_d = cnt_q - ONE;
            CMD_LOAD: cnt_d = load_val_i;
            default:  cnt_d = cnt_q;
        endcase
    end

    generate
        if (ASYNC_RST) begin : g_async
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end
        end else begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end
        end
    endgenerate

    assign cnt_o  = cnt_q;
    assign zero_o = ~|cnt_q;          // NOR of all count bits
    assign one_o  = (cnt_q == ONE);

endmodule

// File: rtl/ipg_ctrl.sv
module ipg_ctrl
    import ipg_pkg::*;
#(
    parameter bit ASYNC_RST = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       cnt_zero_i,
    input  logic       cnt_one_i,
    input  logic       interval_zero_i,
    output ipg_cmd_e   cmd_o,
    output logic       pulse_o,
    output ipg_phase_e phase_o
);

    ipg_phase_e phase_q;
    ipg_phase_e phase_d;

    // Next-state logic
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_TERMINAL: begin
                if (en_i && !interval_zero_i) phase_d = PH_COUNTING;
            end
            PH_COUNTING: begin
                if (en_i && cnt_one_i) phase_d = PH_TERMINAL;
            end
            default: phase_d = PH_TERMINAL;
        endcase
    end

    // State register
    generate
        if (ASYNC_RST) begin : g_async
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) phase_q <= PH_TERMINAL;
                else        phase_q <= phase_d;
            end
        end else begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n) phase_q <= PH_TERMINAL;
                else        phase_q <= phase_d;
            end
        end
    endgenerate

    // Outputs
    always_comb begin
        cmd_o   = CMD_HOLD;
        pulse_o = en_i & cnt_zero_i;
        if (en_i) begin
            unique case (phase_q)
                PH_TERMINAL: cmd_o = CMD_LOAD;
                PH_COUNTING: cmd_o = CMD_DEC;
                default:     cmd_o = CMD_HOLD;
            endcase
        end
    end

    assign phase_o = phase_q;

endmodule

// File: rtl/interval_pulse_gen.sv
module interval_pulse_gen
    import ipg_pkg::*;
#(
    parameter int           W                = 16,
    parameter bit           ASYNC_RST        = 1'b1,
    parameter logic [W-1:0] DEFAULT_INTERVAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         wr_i,
    input  logic [W-1:0] wr_data_i,
    output logic         pulse_o
);

    logic [W-1:0] interval_q;
    logic         interval_zero;
    logic [W-1:0] cnt_q;
    logic         cnt_zero;
    logic         cnt_one;
    ipg_cmd_e     cmd;
    ipg_phase_e   phase;

    ipg_interval_reg #(
        .W         (W),
        .ASYNC_RST (ASYNC_RST),
        .RST_VAL   (DEFAULT_INTERVAL)
    ) u_interval (
        .clk             (clk),
        .rst_n           (rst_n),
        .wr_i            (wr_i),
        .wr_data_i       (wr_data_i),
        .interval_o      (interval_q),
        .interval_zero_o (interval_zero)
    );

    ipg_down_counter #(
        .W         (W),
        .ASYNC_RST (ASYNC_RST)
    ) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_i      (cmd),
        .load_val_i (interval_q),
        .cnt_o      (cnt_q),
        .zero_o     (cnt_zero),
        .one_o      (cnt_one)
    );

    ipg_ctrl #(
        .ASYNC_RST (ASYNC_RST)
    ) u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .en_i            (en_i),
        .cnt_zero_i      (cnt_zero),
        .cnt_one_i       (cnt_one),
        .interval_zero_i (interval_zero),
        .cmd_o           (cmd),
        .pulse_o         (pulse_o),
        .phase_o         (phase)
    );

endmodule

// File: rtl/ipg_checker.sv
module ipg_checker
    import ipg_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         en_i,
    input logic         pulse_o,
    input logic [W-1:0] cnt_q,
    input logic [W-1:0] interval_q,
    input ipg_phase_e   phase
);

    // R2
    reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> (cnt_q == $past(interval_q)));

    // R2
    decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - W'(1)));

    // R2
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_o && (interval_q != '0)) |=> !pulse_o);

    // R3
    zero_interval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_o && (interval_q == '0)) |=> (cnt_q == '0));

    // R4
    hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(cnt_q));

    // R4
    no_pulse_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> !pulse_o);

    // R1
    phase_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_TERMINAL) == (cnt_q == '0)));

endmodule

bind interval_pulse_gen ipg_checker #(.W(W)) u_ipg_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .pulse_o    (pulse_o),
    .cnt_q      (cnt_q),
    .interval_q (interval_q),
    .phase      (phase)
);

// File: tb/interval_pulse_gen_bench.sv
module interval_pulse_gen_bench;

    localparam int W = 16;

    typedef struct {
        logic  exp;
        string tag;
    } sb_item_t;

    logic         clk       = 1'b0;
    logic         rst_n     = 1'b0;
    logic         en_i      = 1'b0;
    logic         wr_i      = 1'b0;
    logic [W-1:0] wr_data_i = '0;
    logic         pulse_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    sb_item_t     sb[$];
    logic [W-1:0] m_cnt = '0;
    logic [W-1:0] m_int = '0;

    always #4 clk = ~clk;

    interval_pulse_gen #(.W(W)) u_interval_pulse_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_i),
        .wr_i      (wr_i),
        .wr_data_i (wr_data_i),
        .pulse_o   (pulse_o)
    );

    // Driver: applies one cycle of stimulus and pushes the expected strobe
    task automatic cyc(input logic en, input logic wr, input logic [W-1:0] d,
                       input string tag);
        sb_item_t it;
        @(posedge clk);
        #1;
        en_i      = en;
        wr_i      = wr;
        wr_data_i = d;
        it.exp = en && (m_cnt == '0);
        it.tag = tag;
        sb.push_back(it);
        if (en) m_cnt = (m_cnt == '0) ? m_int : m_cnt - W'(1);
        if (wr) m_int = d;
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, '0, tag);
    endtask

    // Monitor: compares the strobe away from the active edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            sb_item_t it;
            it = sb.pop_front();
            checks++;
            if (pulse_o !== it.exp) begin
                errors++;
                $display("FAIL %s: pulse_o actual=%b expected=%b at %0t",
                         it.tag, pulse_o, it.exp, $time);
            end
        end
    end

    initial begin
        repeat (199000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R7: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, no strobe while disabled, strobe on first enabled clock
        cyc(1'b0, 1'b0, '0, "R1");
        cyc(1'b0, 1'b0, '0, "R1");
        cyc(1'b1, 1'b0, '0, "R1");

        // R6: default interval of 0 gives a strobe every enabled cycle
        run(5, "R6");

        // R5: write coinciding with a reload is not used by that reload
        cyc(1'b1, 1'b1, W'(5), "R5");
        // R2: period of 6 with interval 5
        run(20, "R2");

        // R5: write in mid-period leaves the running count untouched
        run(2, "R5");
        cyc(1'b1, 1'b1, W'(2), "R5");
        run(16, "R5");

        // R2: interval 1 alternates
        cyc(1'b1, 1'b1, W'(1), "R2");
        run(12, "R2");

        // R4: pause mid-period with interval 4, then resume
        cyc(1'b1, 1'b1, W'(4), "R4");
        run(7, "R4");
        for (int i = 0; i < 7; i++) cyc(1'b0, 1'b0, '0, "R4");
        run(3, "R4");
        cyc(1'b0, 1'b1, W'(4), "R4");
        run(12, "R4");

        // R3: interval 0 strobes on every cycle
        cyc(1'b1, 1'b1, W'(0), "R3");
        run(12, "R3");

        // R7: full-scale interval
        cyc(1'b1, 1'b1, {W{1'b1}}, "R7");
        run(65540, "R7");

        cyc(1'b0, 1'b0, '0, "R4");
        @(negedge clk);
        #1;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule